// File: doc/BRIEF.md
# Nibble Load, Step and Skip Execution Core

This block executes a small family of 4-bit data instructions: immediate loads, moves among an accumulator and two address nibbles, moves and swaps with a 256-entry nibble memory, and increments. The fetch side offers instruction bytes one at a time with a valid/ready handshake. The block holds the accumulator, the high and low address nibbles that together select a memory word, and the memory itself.

Several operations move the low address nibble up or down as a side effect of a memory access. They raise a skip request when that nibble wraps. A program can therefore walk one 16-word row of memory in a tight loop and leave it with no compare instruction. The skip request appears as a one-cycle pulse. The block itself then swallows the next instruction it accepts, including the immediate byte of a two-byte opcode.

Top module: `nib_exec_core`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the accumulator, high nibble and low nibble read zero, the skip output is low and ready is low. Ready is high in every later cycle.
- R2: Byte 0x9n loads n into the accumulator. Byte 0x8n loads n into the low nibble. Each is complete when the byte is accepted.
- R3: Byte 0x15 takes the next accepted byte as an immediate. Its upper four bits go to the high nibble and its lower four bits go to the low nibble. Accepting the 0x15 byte changes no register.
- R4: 0x21 copies low into the accumulator, 0x22 copies high into the accumulator, 0x2D copies the accumulator into low, and 0x2E copies the accumulator into high.
- R5: 0x38 loads the accumulator from memory word {high,low}, and 0x2F stores the accumulator into that word.
- R6: 0x24 (load) and 0x26 (store) access memory at the old address, then add one to low modulo 16. They request a skip when low becomes 0.
- R7: 0x25 (load) and 0x27 (store) access memory at the old address, then subtract one from low modulo 16. They request a skip when low becomes F.
- R8: 0x28 swaps the accumulator with memory word {high,low}. 0x3C does the same swap, then adds one to low and requests a skip when low becomes 0.
- R9: 0x30 adds one to the accumulator, and 0x31 adds one to low. 0x33 writes memory-plus-one into the accumulator and leaves memory unchanged. Each requests a skip when its result is 0, and all wrap modulo 16.
- R10: A skip request drives skip_o high for exactly the one cycle after the edge that accepted the requesting byte.
- R11: After a skip request, the next accepted byte is discarded. It changes no register or memory word and raises no skip. If that byte is 0x15, the byte after it is discarded as well.
- R12: Any byte outside the set above is a one-byte no-operation.
- R13: A byte is accepted only on an edge where ins_valid and ins_ready are both high. Bytes presented with ins_valid low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_valid | input | 1 | Instruction byte on ins_byte is offered |
| ins_byte | input | 8 | Instruction or immediate byte |
| ins_ready | output | 1 | Core can accept a byte this cycle |
| skip_o | output | 1 | One-cycle pulse: next instruction is being dropped |
| acc_o | output | 4 | Accumulator |
| h_o | output | 4 | High address nibble |
| l_o | output | 4 | Low address nibble |

## Verification
A wrong register value shows up on acc_o, h_o or l_o in the cycle after the faulty byte is accepted. A wrong memory word stays hidden until the bench reads it back through 0x38 or a stepping load, so the bench ends with a sweep over all 256 words. A lost or stale discard state is the slowest fault to appear. It shows only when the next accepted byte would have changed a register, or when a dropped 0x15 lets its immediate byte through as an opcode. For that reason the sequences after each skip use bytes whose effect would be visible.

// File: rtl/nib_pkg.sv
package nib_pkg;

    typedef enum logic [4:0] {
        K_NOP,
        K_LD_A_IMM,
        K_LD_L_IMM,
        K_LD_HL_IMM,
        K_A_FROM_L,
        K_L_FROM_A,
        K_A_FROM_H,
        K_H_FROM_A,
        K_A_FROM_M,
        K_M_FROM_A,
        K_A_FROM_M_UP,
        K_A_FROM_M_DN,
        K_M_FROM_A_UP,
        K_M_FROM_A_DN,
        K_SWAP,
        K_SWAP_UP,
        K_INC_A,
        K_INC_L,
        K_INC_M
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     two_byte;
        logic     l_down;
    } op_dec_t;

    typedef struct packed {
        logic [3:0] a;
        logic [3:0] h;
        logic [3:0] l;
        logic       skip;
        logic       drop;
        logic       imm_wait;
        logic       imm_drop;
        logic       rdy;
    } core_st_t;

endpackage

// File: rtl/nib_decode.sv
module nib_decode
    import nib_pkg::*;
(
    input  logic [7:0] op_byte,
    output op_dec_t    dec
);
    always_comb begin
        dec.kind     = K_NOP;
        dec.two_byte = 1'b0;
        dec.l_down   = 1'b0;
        case (op_byte[7:4])
            4'h9: dec.kind = K_LD_A_IMM;
            4'h8: dec.kind = K_LD_L_IMM;
            default: begin
                case (op_byte)
                    8'h15: begin
                        dec.kind     = K_LD_HL_IMM;
                        dec.two_byte = 1'b1;
                    end
                    8'h21: dec.kind = K_A_FROM_L;
                    8'h2D: dec.kind = K_L_FROM_A;
                    8'h22: dec.kind = K_A_FROM_H;
                    8'h2E: dec.kind = K_H_FROM_A;
                    8'h38: dec.kind = K_A_FROM_M;
                    8'h2F: dec.kind = K_M_FROM_A;
                    8'h24: dec.kind = K_A_FROM_M_UP;
                    8'h25: begin
                        dec.kind   = K_A_FROM_M_DN;
                        dec.l_down = 1'b1;
                    end
                    8'h26: dec.kind = K_M_FROM_A_UP;
                    8'h27: begin
                        dec.kind   = K_M_FROM_A_DN;
                        dec.l_down = 1'b1;
                    end
                    8'h28: dec.kind = K_SWAP;
                    8'h3C: dec.kind = K_SWAP_UP;
                    8'h30: dec.kind = K_INC_A;
                    8'h31: dec.kind = K_INC_L;
                    8'h33: dec.kind = K_INC_M;
                    default: dec.kind = K_NOP;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/nib_step.sv
module nib_step #(
    parameter int W = 4
) (
    input  logic [W-1:0] val,
    input  logic         down,
    output logic [W-1:0] res,
    output logic         wrapped
);
    always_comb begin
        if (down) begin
            res     = val - W'(1);
            wrapped = (res == {W{1'b1}});
        end else begin
            res     = val + W'(1);
            wrapped = (res == '0);
        end
    end
endmodule

// File: rtl/nib_dmem.sv
module nib_dmem #(
    parameter int DW = 4,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells_q[addr] <= wdata;
    end

    assign rdata = cells_q[addr];
endmodule

// File: rtl/nib_exec_core.sv
module nib_exec_core
    import nib_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [7:0]    ins_byte,
    output logic          ins_ready,
    output logic          skip_o,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] h_o,
    output logic [DW-1:0] l_o
);
    localparam int AW = 2 * DW;

    core_st_t st_q, st_d;
    op_dec_t  dec;

    logic          fire;
    logic          mem_we;
    logic [DW-1:0] mem_rd;
    logic [DW-1:0] l_nx, a_nx, m_nx;
    logic          l_wrap, a_wrap, m_wrap;
    logic          hit;

    assign fire = ins_valid && st_q.rdy;

    nib_decode u_dec (
        .op_byte (ins_byte),
        .dec     (dec)
    );

    nib_step #(.W(DW)) u_step_l (
        .val     (st_q.l),
        .down    (dec.l_down),
        .res     (l_nx),
        .wrapped (l_wrap)
    );

    nib_step #(.W(DW)) u_step_a (
        .val     (st_q.a),
        .down    (1'b0),
        .res     (a_nx),
        .wrapped (a_wrap)
    );

    nib_step #(.W(DW)) u_step_m (
        .val     (mem_rd),
        .down    (1'b0),
        .res     (m_nx),
        .wrapped (m_wrap)
    );

    nib_dmem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  ({st_q.h, st_q.l}),
        .wdata (st_q.a),
        .rdata (mem_rd)
    );

    always_comb begin
        st_d     = st_q;
        st_d.skip = 1'b0;
        st_d.rdy  = 1'b1;
        mem_we   = 1'b0;
        hit      = 1'b0;
        if (fire) begin
            if (st_q.imm_wait) begin
                st_d.imm_wait = 1'b0;
                if (!st_q.imm_drop) begin
                    st_d.h = ins_byte[7:4];
                    st_d.l = ins_byte[3:0];
                end
            end else if (st_q.drop) begin
                st_d.drop = 1'b0;
                if (dec.two_byte) begin
                    st_d.imm_wait = 1'b1;
                    st_d.imm_drop = 1'b1;
                end
            end else begin
                case (dec.kind)
                    K_LD_A_IMM: st_d.a = ins_byte[3:0];
                    K_LD_L_IMM: st_d.l = ins_byte[3:0];
                    K_LD_HL_IMM: begin
                        st_d.imm_wait = 1'b1;
                        st_d.imm_drop = 1'b0;
                    end
                    K_A_FROM_L: st_d.a = st_q.l;
                    K_L_FROM_A: st_d.l = st_q.a;
                    K_A_FROM_H: st_d.a = st_q.h;
                    K_H_FROM_A: st_d.h = st_q.a;
                    K_A_FROM_M: st_d.a = mem_rd;
                    K_M_FROM_A: mem_we = 1'b1;
                    K_A_FROM_M_UP, K_A_FROM_M_DN: begin
                        st_d.a = mem_rd;
                        st_d.l = l_nx;
                        hit    = l_wrap;
                    end
                    K_M_FROM_A_UP, K_M_FROM_A_DN: begin
                        mem_we = 1'b1;
                        st_d.l = l_nx;
                        hit    = l_wrap;
                    end
                    K_SWAP: begin
                        st_d.a = mem_rd;
                        mem_we = 1'b1;
                    end
                    K_SWAP_UP: begin
                        st_d.a = mem_rd;
                        mem_we = 1'b1;
                        st_d.l = l_nx;
                        hit    = l_wrap;
                    end
                    K_INC_A: begin
                        st_d.a = a_nx;
                        hit    = a_wrap;
                    end
                    K_INC_L: begin
                        st_d.l = l_nx;
                        hit    = l_wrap;
                    end
                    K_INC_M: begin
                        st_d.a = m_nx;
                        hit    = m_wrap;
                    end
                    default: ;
                endcase
                if (hit) begin
                    st_d.skip = 1'b1;
                    st_d.drop = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ins_ready = st_q.rdy;
    assign skip_o    = st_q.skip;
    assign acc_o     = st_q.a;
    assign h_o       = st_q.h;
    assign l_o       = st_q.l;

    a_r10_skip_single: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |=> !skip_o);

    a_r11_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.drop) |=> ($stable(acc_o) && $stable(h_o) && $stable(l_o) && !skip_o));

    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_valid && ins_ready) |=> ($stable(acc_o) && $stable(h_o) && $stable(l_o)));

    a_r9_skip_cause: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (acc_o == '0 || l_o == '0 || l_o == {DW{1'b1}}));

    a_r2_imm_load: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !st_q.drop && !st_q.imm_wait && ins_byte[7:4] == 4'h9)
        |=> (acc_o == $past(ins_byte[3:0])));
endmodule

// File: tb/nib_exec_core_tb_top.sv
module nib_exec_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_valid = 1'b0;
    logic [7:0] ins_byte = 8'h00;
    logic       ins_ready, skip_o;
    logic [3:0] acc_o, h_o, l_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    nib_exec_core dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_byte(ins_byte),
        .ins_ready(ins_ready), .skip_o(skip_o), .acc_o(acc_o), .h_o(h_o), .l_o(l_o)
    );

    // behavioural reference
    int ma, mh, ml, mskip, mrdy, mdrop, mimm, mimmdrop;
    int mem [256];

    always @(posedge clk) begin
        int b, hitv, adr;
        if (!rst_n) begin
            ma = 0; mh = 0; ml = 0; mskip = 0; mrdy = 0;
            mdrop = 0; mimm = 0; mimmdrop = 0;
        end else begin
            hitv = 0;
            if (ins_valid && mrdy == 1) begin
                b = int'(ins_byte);
                adr = mh * 16 + ml;
                if (mimm == 1) begin
                    mimm = 0;
                    if (mimmdrop == 0) begin mh = b / 16; ml = b % 16; end
                end else if (mdrop == 1) begin
                    mdrop = 0;
                    if (b == 'h15) begin mimm = 1; mimmdrop = 1; end
                end else if (b / 16 == 9) ma = b % 16;
                else if (b / 16 == 8) ml = b % 16;
                else begin
                    case (b)
                        'h15: begin mimm = 1; mimmdrop = 0; end
                        'h21: ma = ml;
                        'h2D: ml = ma;
                        'h22: ma = mh;
                        'h2E: mh = ma;
                        'h38: ma = mem[adr];
                        'h2F: mem[adr] = ma;
                        'h24: begin ma = mem[adr]; ml = (ml + 1) % 16; hitv = (ml == 0); end
                        'h25: begin ma = mem[adr]; ml = (ml + 15) % 16; hitv = (ml == 15); end
                        'h26: begin mem[adr] = ma; ml = (ml + 1) % 16; hitv = (ml == 0); end
                        'h27: begin mem[adr] = ma; ml = (ml + 15) % 16; hitv = (ml == 15); end
                        'h28: begin int t; t = ma; ma = mem[adr]; mem[adr] = t; end
                        'h3C: begin
                            int t; t = ma; ma = mem[adr]; mem[adr] = t;
                            ml = (ml + 1) % 16; hitv = (ml == 0);
                        end
                        'h30: begin ma = (ma + 1) % 16; hitv = (ma == 0); end
                        'h31: begin ml = (ml + 1) % 16; hitv = (ml == 0); end
                        'h33: begin ma = (mem[adr] + 1) % 16; hitv = (ma == 0); end
                        default: ;
                    endcase
                    if (hitv == 1) mdrop = 1;
                end
            end
            mskip = hitv;
            mrdy = 1;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("acc", int'(acc_o), ma);
            chk("h", int'(h_o), mh);
            chk("l", int'(l_o), ml);
            chk("skip", int'(skip_o), mskip);
            chk("ready", int'(ins_ready), mrdy);
        end
    end

    task automatic send(input logic [7:0] b);
        ins_valid = 1'b1;
        ins_byte = b;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        ins_valid = 1'b0;
        ins_byte = 8'h30;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset values checked by the per-cycle compare
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // memory fill: rows via stepping store (R6), each row ends with a skip
        tag = "R6";
        for (int hh = 0; hh < 16; hh++) begin
            send(8'h15);
            send(8'(hh * 16));
            for (int ll = 0; ll < 16; ll++) begin
                send(8'h90 | 8'((hh * 3 + ll * 7) % 16));
                send(8'h26);
            end
            tag = "R11";
            send(8'h9F);
            tag = "R6";
        end

        tag = "R2";
        send(8'h95); send(8'h8A); send(8'h90); send(8'h8F);
        tag = "R3";
        send(8'h15); idle(2); send(8'h7C);
        tag = "R4";
        send(8'h21); send(8'h2E); send(8'h93); send(8'h2D); send(8'h22);
        tag = "R5";
        send(8'h15); send(8'h42); send(8'h99); send(8'h2F); send(8'h90); send(8'h38);
        tag = "R6";
        send(8'h15); send(8'h5E); send(8'h24); send(8'h24);
        tag = "R11";
        send(8'h91); send(8'h38);
        tag = "R7";
        send(8'h15); send(8'h61); send(8'h25); send(8'h25);
        tag = "R11";
        send(8'h15); send(8'h33); send(8'h38);
        tag = "R7";
        send(8'h94); send(8'h81); send(8'h27); send(8'h27);
        tag = "R11";
        send(8'h2E); send(8'h38);
        tag = "R8";
        send(8'h15); send(8'h3D); send(8'h96); send(8'h28); send(8'h28);
        send(8'h8F); send(8'h9B); send(8'h3C); send(8'h30); send(8'h38);
        tag = "R9";
        send(8'h9F); send(8'h30); send(8'h8E); send(8'h31); send(8'h31);
        send(8'h30); send(8'h31);
        send(8'h15); send(8'h70); send(8'h9F); send(8'h2F); send(8'h33);
        send(8'h30); send(8'h90); send(8'h38);
        send(8'h94); send(8'h2F); send(8'h33); send(8'h38);
        tag = "R10";
        send(8'h9F); send(8'h30); idle(3); send(8'h92); send(8'h30);
        tag = "R12";
        send(8'h14); send(8'h10); send(8'hFF); send(8'h00); send(8'h11); send(8'h3E);
        tag = "R13";
        idle(5);
        ins_byte = 8'h9A; repeat (2) @(negedge clk);

        // final sweep of every word through the stepping load
        tag = "R5";
        for (int hh = 0; hh < 16; hh++) begin
            send(8'h15);
            send(8'(hh * 16));
            for (int ll = 0; ll < 16; ll++) send(8'h24);
            tag = "R11";
            send(8'h93);
            tag = "R5";
        end
        idle(3);
        finish_run();
    end
endmodule